// File: doc/BRIEF.md
# Selectable-Source Cyclic Timer/Event Counter

This block is a cyclic counter of up to 10 bits. It can serve as a time base or as an event counter. A 3-bit select field picks its count clock from eight sources. Six are prescaler tap levels. Two are external pins. Each pin has a polarity option, and it can be taken either direct or through an external debounce filter. A direct pin is divided by two before it drives the counter. The active length can be 10, 8, 6 or 4 bits. Bits above the active length keep their value. The counter counts up or down and wraps around in either direction. It raises a one-cycle roll-over pulse when the active bits reach their terminal value.

The whole block runs on the system clock. Pin levels pass through a two-flop synchroniser. Every source is turned into one-cycle rising-edge and falling-edge strobes. A control register holds the settings and is written with a strobe. A load strobe writes a start value into the count. When event mode is off, counting starts only after a falling edge of the selected clock has been seen with the start bit set. This prevents a short first period.

Top module: `tmr_evt_counter`

## Requirements
- R1: After reset, `cnt_o` is 0, `irq_o` is 0, and the control register is cleared (select 0, count down, 10-bit length, event mode off, start 0, polarity normal, direct pins). Source edges therefore do not change the count.
- R2: Select values 0 to 5 take prescaler tap `tap_i[sel]`. Value 6 takes pin 0 and value 7 takes pin 1. Edges on sources that are not selected have no effect on the count.
- R3: In up mode (`up_i`=1), a count step adds one to the active low bits modulo 2^L, and wraps from all ones to zero. Bits above the active length are unchanged by a step.
- R4: In down mode (`up_i`=0), a count step subtracts one from the active bits, and wraps from zero to all ones.
- R5: Length code `len_i` gives L = 10 − 2·code (00→10, 01→8, 10→6, 11→4). In up mode, `irq_o` pulses when a step leaves the active bits all ones (3FF, FF, 3F or F).
- R6: In down mode, `irq_o` pulses when a step leaves the active bits at zero.
- R7: While start is 0, the count holds its value and the start-up latch is cleared. A `load_i` strobe writes `load_val_i` into the count whatever the start bit is, and it never raises `irq_o`.
- R8: With event mode off (`evt_i`=0), a rising edge of the selected clock steps the count only after a falling edge of that clock has been seen while start was already 1.
- R9: With event mode on (`evt_i`=1), every rising edge of the selected clock steps the count while start is 1. No prior falling edge is needed.
- R10: When `inv_i[p]`=1, pin p is inverted before edge detection. A falling pin level is then a rising edge of the source.
- R11: For a direct pin (`deb_i[p]`=0), the source is the pin divided by two. It has a rising edge on every odd-numbered falling edge of the (polarity-corrected) pin since reset, and a falling edge on every even-numbered one.
- R12: For a debounced pin (`deb_i[p]`=1), the source is `pin_filt_i[p]` with no division. In this mode the raw `pin_i[p]` has no effect.
- R13: `irq_o` lasts one clock cycle. It is high in the same cycle in which `cnt_o` first shows the terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_i | input | 6 | Prescaler tap levels, synchronous to clk_i |
| pin_i | input | 2 | Raw external pin levels (asynchronous) |
| pin_filt_i | input | 2 | Debounced versions of the pins |
| ctl_we_i | input | 1 | Writes the control fields below into the control register |
| sel_i | input | 3 | Count source select |
| up_i | input | 1 | Direction: 1 up, 0 down |
| len_i | input | 2 | Active length code |
| evt_i | input | 1 | Event mode (start without a prior falling edge) |
| start_i | input | 1 | Counter run enable |
| inv_i | input | 2 | Per-pin polarity inversion |
| deb_i | input | 2 | Per-pin debounced (1) or direct (0) |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 10 | Value written by load_i |
| cnt_o | output | 10 | Current count |
| irq_o | output | 1 | Roll-over pulse |

## Verification
The hardest state to reach is the direct-pin divider phase combined with the start-up latch. Whether a pin falling edge steps the count depends on how many falling edges came before it since reset. It also depends on whether a divided falling edge arrived after start was set. Polarity or debounce changes in the control register can add extra edges, and these shift that parity. The stimulus mixes directed pin sequences with random interleaving of pin, filter, tap, control and load actions. A bench model tracks edge parity and the latch per source, so each such case lands on a predicted count and pulse total.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W    = 10;
  localparam int unsigned NUM_TAPS = 6;
  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned NUM_SRC  = NUM_TAPS + NUM_PINS;
  localparam int unsigned SEL_W    = $clog2(NUM_SRC);
  localparam int unsigned LEN_W    = 2;

  typedef struct packed {
    logic [SEL_W-1:0]    sel;
    logic                up;
    logic [LEN_W-1:0]    len;
    logic                evt;
    logic                start;
    logic [NUM_PINS-1:0] inv;
    logic [NUM_PINS-1:0] deb;
  } ctl_t;

  // active-bit mask: length = CNT_W - 2*len
  function automatic logic [CNT_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> (2 * int'(len));
  endfunction
endpackage

// File: rtl/tmr_pin_src.sv
module tmr_pin_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic filt_i,
  input  logic inv_i,
  input  logic deb_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl, sync1_q, sync2_q, prev_q, div_q;
  logic raw_rise, raw_fall;

  assign lvl = (deb_i ? filt_i : pin_i) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= lvl;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign raw_rise = sync2_q & ~prev_q;
  assign raw_fall = ~sync2_q & prev_q;

  // divide-by-two on falling edges in direct mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= 1'b0;
    else if (!deb_i && raw_fall)  div_q <= ~div_q;
  end

  assign rise_o = deb_i ? raw_rise : (raw_fall & ~div_q);
  assign fall_o = deb_i ? raw_fall : (raw_fall &  div_q);

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R11
  AST_DIRECT_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deb_i && rise_o) |=> (div_q || deb_i)); // R11
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_filt_i,
  input  logic [NUM_PINS-1:0] inv_i,
  input  logic [NUM_PINS-1:0] deb_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                rise_o,
  output logic                fall_o
);
  logic [NUM_SRC-1:0]  rise_all, fall_all;
  logic [NUM_TAPS-1:0] tap_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_prev_q <= '0;
    else         tap_prev_q <= tap_i;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign rise_all[t] =  tap_i[t] & ~tap_prev_q[t];
    assign fall_all[t] = ~tap_i[t] &  tap_prev_q[t];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    tmr_pin_src u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[p]),
      .filt_i (pin_filt_i[p]),
      .inv_i  (inv_i[p]),
      .deb_i  (deb_i[p]),
      .rise_o (rise_all[NUM_TAPS+p]),
      .fall_o (fall_all[NUM_TAPS+p])
    );
  end

  assign rise_o = rise_all[sel_i];
  assign fall_o = fall_all[sel_i];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             start_i,
  input  logic             evt_i,
  input  logic             up_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, mask, stepped, nxt;
  logic             armed_q, step, irq_q;

  assign mask    = len_mask(len_i);
  assign step    = start_i && rise_i && (evt_i || armed_q);
  assign stepped = up_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  assign nxt     = (cnt_q & ~mask) | (stepped & mask);

  // start-up latch: a falling edge must be seen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b0;
    else if (!start_i)            armed_q <= 1'b0;
    else if (!evt_i && fall_i)    armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (step) begin
        cnt_q <= nxt;
        irq_q <= ((nxt & mask) == (up_i ? mask : '0));
      end
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !load_i) |=> $stable(cnt_q)); // R7
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask)))); // R3
  AST_IRQ_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ((cnt_q & $past(mask)) == ($past(up_i) ? $past(mask) : '0))); // R5
  AST_NO_STEP_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && start_i && !evt_i && !armed_q && !load_i) |=> $stable(cnt_q)); // R8
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !irq_q); // R7
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter
  import tmr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TAPS-1:0]  tap_i,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic [NUM_PINS-1:0]  pin_filt_i,
  input  logic                 ctl_we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 up_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 evt_i,
  input  logic                 start_i,
  input  logic [NUM_PINS-1:0]  inv_i,
  input  logic [NUM_PINS-1:0]  deb_i,
  input  logic                 load_i,
  input  logic [CNT_W-1:0]     load_val_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 irq_o
);
  ctl_t ctl_q;
  logic src_rise, src_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q.sel   <= sel_i;
      ctl_q.up    <= up_i;
      ctl_q.len   <= len_i;
      ctl_q.evt   <= evt_i;
      ctl_q.start <= start_i;
      ctl_q.inv   <= inv_i;
      ctl_q.deb   <= deb_i;
    end
  end

  tmr_src_sel u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tap_i      (tap_i),
    .pin_i      (pin_i),
    .pin_filt_i (pin_filt_i),
    .inv_i      (ctl_q.inv),
    .deb_i      (ctl_q.deb),
    .sel_i      (ctl_q.sel),
    .rise_o     (src_rise),
    .fall_o     (src_fall)
  );

  tmr_count_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (src_rise),
    .fall_i     (src_fall),
    .start_i    (ctl_q.start),
    .evt_i      (ctl_q.evt),
    .up_i       (ctl_q.up),
    .len_i      (ctl_q.len),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .cnt_o      (cnt_o),
    .irq_o      (irq_o)
  );

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R13
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.start && !load_i) |=> !irq_o); // R1
endmodule

// File: tb/sim_tmr_evt_counter.sv
module sim_tmr_evt_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [5:0] tap = '0;
  logic [1:0] pin = '0, filt = '0;
  logic       we = 1'b0, d_up = 1'b0, d_evt = 1'b0, d_start = 1'b0, load = 1'b0;
  logic [2:0] d_sel = '0;
  logic [1:0] d_len = '0, d_inv = '0, d_deb = '0;
  logic [9:0] load_val = '0, cnt;
  logic       irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .tap_i(tap), .pin_i(pin), .pin_filt_i(filt),
    .ctl_we_i(we), .sel_i(d_sel), .up_i(d_up), .len_i(d_len), .evt_i(d_evt),
    .start_i(d_start), .inv_i(d_inv), .deb_i(d_deb), .load_i(load),
    .load_val_i(load_val), .cnt_o(cnt), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int irq_seen = 0, irq_exp = 0;

  // reference model state
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_div[2] = '{0, 0};
  bit m_tap_prev[6] = '{0, 0, 0, 0, 0, 0};
  bit m_pin_prev[2] = '{0, 0};
  int c_sel = 0, c_len = 0;
  bit c_up = 0, c_evt = 0, c_start = 0;
  bit c_inv[2] = '{0, 0};
  bit c_deb[2] = '{0, 0};

  function automatic int msk(int len);
    return (1 << (10 - 2 * len)) - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R13: pulse coincides with terminal value on cnt_o
  always @(negedge clk) if (rst_n && irq) begin
    irq_seen++;
    chk("R13", cnt & msk(c_len), c_up ? msk(c_len) : 0);
  end

  task automatic m_step();
    int mk = msk(c_len);
    int nv = c_up ? m_cnt + 1 : m_cnt - 1;
    m_cnt = (m_cnt & ~mk & 'h3FF) | (nv & mk);
    if ((m_cnt & mk) == (c_up ? mk : 0)) irq_exp++;
  endtask

  task automatic m_edge(bit is_rise);
    if (!c_start) return;
    if (is_rise) begin
      if (c_evt || m_armed) m_step();
    end else if (!c_evt) m_armed = 1;
  endtask

  task automatic m_update();
    for (int i = 0; i < 6; i++) begin
      bit lv = tap[i];
      if (lv != m_tap_prev[i]) begin
        m_tap_prev[i] = lv;
        if (c_sel == i) m_edge(lv);
      end
    end
    for (int p = 0; p < 2; p++) begin
      bit lv = (c_deb[p] ? filt[p] : pin[p]) ^ c_inv[p];
      if (lv != m_pin_prev[p]) begin
        m_pin_prev[p] = lv;
        if (c_deb[p]) begin
          if (c_sel == 6 + p) m_edge(lv);
        end else if (!lv) begin
          m_div[p] = ~m_div[p];
          if (c_sel == 6 + p) m_edge(m_div[p]);
        end
      end
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_ctl(int sel, bit up, int len, bit evt, bit start, bit [1:0] inv, bit [1:0] deb);
    @(negedge clk);
    we = 1; d_sel = 3'(sel); d_up = up; d_len = 2'(len); d_evt = evt;
    d_start = start; d_inv = inv; d_deb = deb;
    @(negedge clk);
    we = 0;
    c_sel = sel; c_up = up; c_len = len; c_evt = evt; c_start = start;
    c_inv[0] = inv[0]; c_inv[1] = inv[1]; c_deb[0] = deb[0]; c_deb[1] = deb[1];
    if (!start) m_armed = 0;
    m_update();
    settle();
  endtask

  task automatic set_tap(int i, bit v);
    @(negedge clk); tap[i] = v; m_update(); settle();
  endtask

  task automatic set_pin(int p, bit v);
    @(negedge clk); pin[p] = v; m_update(); settle();
  endtask

  task automatic set_filt(int p, bit v);
    @(negedge clk); filt[p] = v; m_update(); settle();
  endtask

  task automatic tap_pulse(int i);
    set_tap(i, 1); set_tap(i, 0);
  endtask

  task automatic pin_pulse(int p);
    set_pin(p, ~pin[p]); set_pin(p, ~pin[p]);
  endtask

  task automatic do_load(int v);
    @(negedge clk); load = 1; load_val = 10'(v);
    @(negedge clk); load = 0; m_cnt = v; settle();
  endtask

  task automatic check_all(string req);
    chk(req, int'(cnt), m_cnt);
    chk(req, irq_seen, irq_exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int unsigned seed = $urandom(32'h1bad5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R1", int'(cnt), 0);
    chk("R1", int'(irq), 0);
    tap_pulse(0);                       // start=0 after reset
    check_all("R1");
    tap_pulse(0);
    check_all("R7");

    // R8: rise before any fall does not count
    wr_ctl(0, 1, 0, 0, 1, 2'b00, 2'b00);
    set_tap(0, 1);
    check_all("R8");
    set_tap(0, 0);
    set_tap(0, 1);
    chk("R8", int'(cnt), 1);
    check_all("R3");
    set_tap(0, 0);

    // R5/R3: 10-bit up wrap with pulse
    do_load('h3FE);
    tap_pulse(0);
    check_all("R5");
    tap_pulse(0);
    chk("R3", int'(cnt), 0);
    check_all("R3");

    // R5/R3: 4-bit length, upper bits held
    wr_ctl(0, 1, 3, 0, 1, 2'b00, 2'b00);
    do_load('h12E);
    tap_pulse(0);
    chk("R5", int'(cnt), 'h12F);
    tap_pulse(0);
    chk("R3", int'(cnt), 'h120);
    check_all("R5");

    // R6/R4: 8-bit down
    wr_ctl(0, 0, 1, 0, 1, 2'b00, 2'b00);
    do_load('h301);
    tap_pulse(0);
    chk("R6", int'(cnt), 'h300);
    tap_pulse(0);
    chk("R4", int'(cnt), 'h3FF);
    check_all("R6");

    // R7: stopped holds, clears latch
    wr_ctl(0, 1, 0, 0, 0, 2'b00, 2'b00);
    tap_pulse(0);
    check_all("R7");
    wr_ctl(0, 1, 0, 0, 1, 2'b00, 2'b00);
    set_tap(0, 1);
    check_all("R7");
    set_tap(0, 0);

    // R9: event mode counts first rise
    wr_ctl(0, 1, 0, 1, 0, 2'b00, 2'b00);
    wr_ctl(0, 1, 0, 1, 1, 2'b00, 2'b00);
    set_tap(0, 1);
    check_all("R9");
    set_tap(0, 0);

    // R2: unselected tap ignored
    wr_ctl(2, 1, 0, 1, 1, 2'b00, 2'b00);
    tap_pulse(0);
    check_all("R2");
    tap_pulse(2);
    check_all("R2");

    // R11: direct pin 0 divided by two
    wr_ctl(6, 1, 2, 0, 1, 2'b00, 2'b00);
    for (int k = 0; k < 5; k++) begin
      pin_pulse(0);
      check_all("R11");
    end

    // R10: inverted polarity on pin 0
    wr_ctl(6, 0, 2, 1, 1, 2'b01, 2'b00);
    for (int k = 0; k < 3; k++) pin_pulse(0);
    check_all("R10");

    // R12: debounced pin 1 uses filtered input only
    wr_ctl(7, 1, 3, 1, 1, 2'b00, 2'b10);
    pin_pulse(1);
    check_all("R12");
    set_filt(1, 1); set_filt(1, 0);
    set_filt(1, 1); set_filt(1, 0);
    check_all("R12");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int a = int'($urandom % 10);
      case (a)
        0, 1, 2: set_tap(int'($urandom % 6), 1'($urandom));
        3, 4:    set_pin(int'($urandom % 2), 1'($urandom));
        5, 6:    set_filt(int'($urandom % 2), 1'($urandom));
        7:       do_load(int'($urandom % 1024));
        default: wr_ctl(int'($urandom % 8), 1'($urandom), int'($urandom % 4),
                        1'($urandom), ($urandom % 4) != 0,
                        2'($urandom), 2'($urandom));
      endcase
      if (it % 8 == 7) check_all("R2");
    end
    check_all("R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule